// File: doc/BRIEF.md
# Indirect-Access Event Counter Bank

This block keeps event counts for sixteen transmit and sixteen receive links. Each transmit link has two counters and each receive link has three, so the bank holds 80 counters. A counter adds one in every clock cycle in which its event strobe is high. Counters that belong to a receive link count only while that link's receive port is enabled.

Software never addresses a counter directly. It first writes a counter index into a select register. It then issues a command. A read command copies the selected counter into a pair of staging registers. A write command loads the staging pair into the selected counter. Two further commands set or clear the selected counter's interrupt enable. When a counter wraps and its interrupt enable is set, the bank raises a one-cycle wrap pulse for that counter.

In latching mode the bank works on intervals. On each latch event, every counter is copied at the same moment into its own 16-bit shadow register, and then every counter is cleared. The latch event comes from one of three sources: a rising edge on an asynchronous frame pulse, every 8000th such edge, or a software command. In this mode counters are 16 bits wide, and a read returns the shadow value. Outside latching mode, counters are 24 bits wide.

Top module: `evt_counter_bank`

## Requirements
- R1: Transmit strobe `tx_evt[2*l+k]` drives counter index 2*l+k. Receive strobe `rx_evt[3*l+k]` drives counter index 32+3*l+k. Each cycle with the strobe high adds exactly one to that counter, and no other counter changes.
- R2: A receive counter of link l counts only while `rx_port_en[l]` is 1. Transmit counters ignore `rx_port_en`.
- R3: A command whose low three bits are 101 is a READ. When the select register holds a valid index, a READ sets the staging outputs at the next clock edge as follows: `stage_hi[7:0]` gets counter bits 23:16, `stage_hi[15:8]` is 0, and `stage_lo` gets counter bits 15:0.
- R4: The staging outputs change only on a READ or on a direct write to a staging register. Counter events and writes to the select register leave them unchanged.
- R5: A command whose low three bits are 001 is a WRITE. A WRITE loads {`stage_hi[7:0]`, `stage_lo`} into the selected counter. If an event strobe arrives for that counter in the same cycle, the WRITE takes precedence.
- R6: Outside latching mode, a counter at 0xFFFFFF wraps to 0 on its next event. In latching mode, a counter wraps to 0 when its low 16 bits are 0xFFFF.
- R7: Command low four bits 1010 set the selected counter's interrupt enable. Command low five bits 00010 clear it. The enable is 0 after reset. `irq_wrap[i]` is high for exactly the one cycle after a wrap of counter i, and only when that counter's enable is set.
- R8: When `latch_mode` is 1, each latch event does three things at one clock edge. It copies the low 16 bits of every counter into that counter's shadow. It clears every counter. Any increment that arrives in that same cycle is counted as 1 in the new interval.
- R9: When `latch_mode` is 1, a READ returns {0, shadow} instead of the live counter, and a WRITE has no effect.
- R10: `latch_src` selects the latch event. With 0, each synchronised rising edge of `frame_pulse` is a latch event. With 1, every 8000th rising edge is a latch event. With 2, a command with low five bits 10010 is a latch event. With 3, nothing latches. Sources that are not selected have no effect.
- R11: When the select register holds an index of 80 or more, READ, WRITE and the interrupt-enable commands have no effect.
- R12: After reset, all counters, shadows, staging outputs, interrupt enables and `irq_wrap` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_evt | input | 32 | Transmit event strobes, two per link |
| rx_evt | input | 48 | Receive event strobes, three per link |
| rx_port_en | input | 16 | Receive port enable, one bit per link |
| sel_we | input | 1 | Write strobe for the select register |
| sel_wdata | input | 7 | Counter index |
| stage_hi_we | input | 1 | Write strobe for the top staging byte |
| stage_hi_wdata | input | 8 | Top staging byte |
| stage_lo_we | input | 1 | Write strobe for the lower staging half |
| stage_lo_wdata | input | 16 | Lower staging half |
| stage_hi | output | 16 | Staged counter bits 23:16, zero-extended |
| stage_lo | output | 16 | Staged counter bits 15:0 |
| cmd_we | input | 1 | Command strobe |
| cmd_wdata | input | 5 | Command code |
| latch_mode | input | 1 | 1 selects latching mode |
| latch_src | input | 2 | Latch event source |
| frame_pulse | input | 1 | Asynchronous frame pulse |
| irq_wrap | output | 80 | One-cycle wrap pulse for each counter |

## Verification
The bench targets several coincidences:
- An event strobe arriving in the same cycle as the latch edge. A design that drops it, or places it in the old interval, reports a shadow or counter value that is off by one.
- An event strobe arriving in the same cycle as a WRITE. A design that lets the increment win leaves the preload value plus one.
- The 16-bit and 24-bit wrap points, each with and without the interrupt enable. A design that uses the wrong width misses the wrap pulse or wraps late, and a missing gate fires a pulse while masked.

The prescaler is driven with 7999 edges and then one more; an off-by-one divider latches one edge early or one late. The bench also covers select indices past the end of the bank, WRITE while latching, and receive ports that are disabled. A design that ignores any of these changes the staging outputs or a count that should have stayed the same.

// File: rtl/evt_counter_bank.sv
`timescale 1ns/1ps
module evt_counter_bank #(
  parameter int N_LINKS  = 16,
  parameter int TX_PER   = 2,
  parameter int RX_PER   = 3,
  parameter int CW       = 24,
  parameter int NW       = 16,
  parameter int PRESCALE = 8000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_LINKS*TX_PER-1:0] tx_evt,
  input  logic [N_LINKS*RX_PER-1:0] rx_evt,
  input  logic [N_LINKS-1:0]    rx_port_en,
  input  logic                  sel_we,
  input  logic [$clog2(N_LINKS*(TX_PER+RX_PER))-1:0] sel_wdata,
  input  logic                  stage_hi_we,
  input  logic [CW-17:0]        stage_hi_wdata,
  input  logic                  stage_lo_we,
  input  logic [15:0]           stage_lo_wdata,
  output logic [15:0]           stage_hi,
  output logic [15:0]           stage_lo,
  input  logic                  cmd_we,
  input  logic [4:0]            cmd_wdata,
  input  logic                  latch_mode,
  input  logic [1:0]            latch_src,
  input  logic                  frame_pulse,
  output logic [N_LINKS*(TX_PER+RX_PER)-1:0] irq_wrap
);
  localparam int NTX   = N_LINKS * TX_PER;
  localparam int NRX   = N_LINKS * RX_PER;
  localparam int NUM   = NTX + NRX;
  localparam int IDX_W = $clog2(NUM);
  localparam int PS_W  = $clog2(PRESCALE + 1);

  logic [IDX_W-1:0] sel_q;
  logic [CW-17:0]   hi_q;
  logic [CW-1:0]    cnt    [NUM];
  logic [NW-1:0]    shadow [NUM];
  logic [CW-1:0]    nxt    [NUM];
  logic [NUM-1:0]   hit, wrap, irq_en;
  logic [PS_W-1:0]  pre_q;
  logic             fp_s1, fp_s2, fp_d;

  wire sel_ok = sel_q < IDX_W'(NUM);
  wire is_rd  = cmd_we && cmd_wdata[2:0] == 3'b101;
  wire is_wr  = cmd_we && cmd_wdata[2:0] == 3'b001;
  wire is_en  = cmd_we && cmd_wdata[3:0] == 4'b1010;
  wire is_dis = cmd_we && cmd_wdata      == 5'b00010;
  wire is_sw  = cmd_we && cmd_wdata      == 5'b10010;

  wire do_read  = is_rd && sel_ok;
  wire do_write = is_wr && sel_ok && !latch_mode;

  wire fp_rise = fp_s2 && !fp_d;
  wire pre_on  = latch_mode && latch_src == 2'd1;
  wire pre_tc  = fp_rise && pre_q == PS_W'(PRESCALE - 1);
  wire latch_fire = latch_mode &&
                    ((latch_src == 2'd0 && fp_rise) ||
                     (latch_src == 2'd1 && pre_tc)  ||
                     (latch_src == 2'd2 && is_sw));

  wire [CW-1:0] rd_val = latch_mode ? {{(CW-NW){1'b0}}, shadow[sel_q]} : cnt[sel_q];

  assign stage_hi = {{(32-CW){1'b0}}, hi_q};

  always_comb begin
    for (int i = 0; i < NTX; i++) hit[i] = tx_evt[i];
    for (int j = 0; j < NRX; j++) hit[NTX+j] = rx_evt[j] && rx_port_en[j/RX_PER];
  end

  always_comb begin
    for (int i = 0; i < NUM; i++) begin
      if (latch_mode) begin
        wrap[i] = cnt[i][NW-1:0] == {NW{1'b1}};
        nxt[i]  = {{(CW-NW){1'b0}}, NW'(cnt[i][NW-1:0] + 1'b1)};
      end else begin
        wrap[i] = cnt[i] == {CW{1'b1}};
        nxt[i]  = cnt[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_s1 <= 1'b0;
      fp_s2 <= 1'b0;
      fp_d  <= 1'b0;
      pre_q <= '0;
    end else begin
      fp_s1 <= frame_pulse;
      fp_s2 <= fp_s1;
      fp_d  <= fp_s2;
      if (!pre_on)     pre_q <= '0;
      else if (fp_rise) pre_q <= pre_tc ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      hi_q     <= '0;
      stage_lo <= '0;
    end else begin
      if (sel_we) sel_q <= sel_wdata;
      if (do_read) begin
        hi_q     <= rd_val[CW-1:16];
        stage_lo <= rd_val[15:0];
      end else begin
        if (stage_hi_we) hi_q     <= stage_hi_wdata;
        if (stage_lo_we) stage_lo <= stage_lo_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en   <= '0;
      irq_wrap <= '0;
      for (int i = 0; i < NUM; i++) begin
        cnt[i]    <= '0;
        shadow[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM; i++) begin
        irq_wrap[i] <= 1'b0;
        if (latch_fire) begin
          shadow[i] <= cnt[i][NW-1:0];
          cnt[i]    <= hit[i] ? CW'(1) : '0;
        end else if (do_write && sel_q == IDX_W'(i)) begin
          cnt[i] <= {hi_q, stage_lo};
        end else if (hit[i]) begin
          cnt[i]      <= nxt[i];
          irq_wrap[i] <= wrap[i] && irq_en[i];
        end
        if (sel_ok && sel_q == IDX_W'(i)) begin
          if (is_en)       irq_en[i] <= 1'b1;
          else if (is_dis) irq_en[i] <= 1'b0;
        end
      end
    end
  end

  a_r4_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we && !stage_hi_we && !stage_lo_we |=> $stable(stage_hi) && $stable(stage_lo));

  a_r10_prescale_range: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q < PS_W'(PRESCALE));

  for (genvar g = 0; g < NUM; g++) begin : g_chk
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq_wrap[g] |-> $past(irq_en[g]));
    a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      irq_wrap[g] |-> cnt[g] == '0);
    a_r8_latch_clears: assert property (@(posedge clk) disable iff (!rst_n)
      latch_fire |=> cnt[g] <= CW'(1));
  end
endmodule

// File: tb/evt_counter_bank_test.sv
`timescale 1ns/1ps
module evt_counter_bank_test;
  localparam logic [4:0] C_RD = 5'b00101, C_WR = 5'b00001, C_EN = 5'b01010,
                         C_DIS = 5'b00010, C_SW = 5'b10010;
  logic clk = 0, rst_n = 0;
  logic [31:0] tx_evt = '0;
  logic [47:0] rx_evt = '0;
  logic [15:0] rx_port_en = '1;
  logic sel_we = 0, stage_hi_we = 0, stage_lo_we = 0, cmd_we = 0;
  logic [6:0] sel_wdata = '0;
  logic [7:0] stage_hi_wdata = '0;
  logic [15:0] stage_lo_wdata = '0;
  logic [15:0] stage_hi, stage_lo;
  logic [4:0] cmd_wdata = '0;
  logic latch_mode = 0, frame_pulse = 0;
  logic [1:0] latch_src = 2'd3;
  logic [79:0] irq_wrap;
  int total = 0, bad = 0;
  bit done = 0;

  evt_counter_bank uut (
    .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .rx_evt(rx_evt), .rx_port_en(rx_port_en),
    .sel_we(sel_we), .sel_wdata(sel_wdata), .stage_hi_we(stage_hi_we),
    .stage_hi_wdata(stage_hi_wdata), .stage_lo_we(stage_lo_we), .stage_lo_wdata(stage_lo_wdata),
    .stage_hi(stage_hi), .stage_lo(stage_lo), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .latch_mode(latch_mode), .latch_src(latch_src), .frame_pulse(frame_pulse),
    .irq_wrap(irq_wrap));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; tx_evt = '0; rx_evt = '0; rx_port_en = '1; latch_mode = 0;
    latch_src = 2'd3; frame_pulse = 0; cmd_we = 0; sel_we = 0;
    stage_hi_we = 0; stage_lo_we = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic cmd(input logic [4:0] c);
    cmd_we = 1; cmd_wdata = c;
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic sel(input logic [6:0] i);
    sel_we = 1; sel_wdata = i;
    @(negedge clk);
    sel_we = 0;
  endtask

  task automatic rd(input logic [6:0] i, output logic [23:0] v);
    sel(i);
    cmd(C_RD);
    v = {stage_hi[7:0], stage_lo};
  endtask

  task automatic stage(input logic [23:0] v);
    stage_hi_we = 1; stage_lo_we = 1;
    stage_hi_wdata = v[23:16]; stage_lo_wdata = v[15:0];
    @(negedge clk);
    stage_hi_we = 0; stage_lo_we = 0;
  endtask

  task automatic wr(input logic [6:0] i, input logic [23:0] v);
    stage(v);
    sel(i);
    cmd(C_WR);
  endtask

  task automatic ptx(input int b, input int n);
    for (int k = 0; k < n; k++) begin
      tx_evt[b] = 1; @(negedge clk); tx_evt[b] = 0;
    end
  endtask

  task automatic prx(input int b, input int n);
    for (int k = 0; k < n; k++) begin
      rx_evt[b] = 1; @(negedge clk); rx_evt[b] = 0;
    end
  endtask

  task automatic fpulse();
    frame_pulse = 1; repeat (2) @(negedge clk);
    frame_pulse = 0; repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [23:0] v;
    do_reset();
    chk("R12 stage_hi", stage_hi, 0);
    chk("R12 stage_lo", stage_lo, 0);
    chk("R12 irq_wrap", irq_wrap, 0);
    rd(7'd10, v);
    chk("R12 counter", v, 0);
  endtask

  task automatic t_map();
    logic [23:0] v;
    do_reset();
    ptx(0, 1); ptx(31, 2); prx(0, 3); prx(47, 4);
    tx_evt[6] = 1; rx_evt[20] = 1; @(negedge clk); @(negedge clk); tx_evt[6] = 0; rx_evt[20] = 0;
    rd(7'd0, v);  chk("R1 tx idx0", v, 1);
    rd(7'd31, v); chk("R1 tx idx31", v, 2);
    rd(7'd32, v); chk("R1 rx idx32", v, 3);
    rd(7'd79, v); chk("R1 rx idx79", v, 4);
    rd(7'd6, v);  chk("R1 held strobe", v, 2);
    rd(7'd52, v); chk("R1 rx idx52", v, 2);
    rd(7'd30, v); chk("R1 neighbour", v, 0);
  endtask

  task automatic t_rxen();
    logic [23:0] v;
    do_reset();
    rx_port_en = 16'hFFDF;
    prx(15, 2); ptx(10, 1);
    rd(7'd47, v); chk("R2 disabled rx", v, 0);
    rd(7'd10, v); chk("R2 tx ignores enable", v, 1);
    rx_port_en = 16'h0020;
    prx(15, 1); prx(0, 1);
    rd(7'd47, v); chk("R2 enabled rx", v, 1);
    rd(7'd32, v); chk("R2 other link off", v, 0);
  endtask

  task automatic t_read_hold();
    logic [23:0] v;
    do_reset();
    wr(7'd12, 24'hA5C3E1);
    rd(7'd12, v);
    chk("R3 stage_hi", stage_hi, 16'h00A5);
    chk("R3 stage_lo", stage_lo, 16'hC3E1);
    ptx(12, 3);
    sel(7'd40);
    chk("R4 hold hi", stage_hi, 16'h00A5);
    chk("R4 hold lo", stage_lo, 16'hC3E1);
    rd(7'd12, v); chk("R4 next read", v, 24'hA5C3E4);
  endtask

  task automatic t_write_override();
    logic [23:0] v;
    do_reset();
    stage(24'h010203); sel(7'd20);
    cmd_we = 1; cmd_wdata = C_WR; tx_evt[20] = 1;
    @(negedge clk);
    cmd_we = 0; tx_evt[20] = 0;
    rd(7'd20, v); chk("R5 write wins", v, 24'h010203);
    ptx(20, 1);
    rd(7'd20, v); chk("R5 counts on", v, 24'h010204);
  endtask

  task automatic t_wrap_irq();
    logic [23:0] v;
    do_reset();
    wr(7'd3, 24'hFFFFFF);
    tx_evt[3] = 1; @(negedge clk); tx_evt[3] = 0;
    chk("R7 masked no pulse", irq_wrap, 0);
    rd(7'd3, v); chk("R6 24-bit wrap", v, 0);
    wr(7'd3, 24'hFFFFFE);
    cmd(C_EN);
    tx_evt[3] = 1; @(negedge clk); tx_evt[3] = 0;
    chk("R7 pre-wrap none", irq_wrap, 0);
    tx_evt[3] = 1; @(negedge clk); tx_evt[3] = 0;
    chk("R7 wrap pulse", irq_wrap, 80'd1 << 3);
    @(negedge clk);
    chk("R7 pulse one cycle", irq_wrap, 0);
    wr(7'd3, 24'hFFFFFF);
    cmd(C_DIS);
    tx_evt[3] = 1; @(negedge clk); tx_evt[3] = 0;
    chk("R7 disabled", irq_wrap, 0);
  endtask

  task automatic t_latch_direct();
    logic [23:0] v;
    do_reset();
    latch_mode = 1; latch_src = 2'd0;
    prx(8, 3); ptx(1, 2);
    fpulse();
    rd(7'd40, v); chk("R8 shadow rx", v, 3);
    rd(7'd1, v);  chk("R8 shadow tx", v, 2);
    prx(8, 1);
    rd(7'd40, v); chk("R9 read shows shadow", v, 3);
    frame_pulse = 1; @(negedge clk); @(negedge clk);
    tx_evt[1] = 1; @(negedge clk); tx_evt[1] = 0;
    frame_pulse = 0; repeat (3) @(negedge clk);
    rd(7'd40, v); chk("R8 cleared then 1", v, 1);
    rd(7'd1, v);  chk("R8 interval no new", v, 0);
    fpulse();
    rd(7'd1, v);  chk("R8 coincident event kept", v, 1);
    wr(7'd5, 24'h001234);
    fpulse();
    rd(7'd5, v);  chk("R9 write ignored", v, 0);
  endtask

  task automatic t_latch_sw();
    logic [23:0] v;
    do_reset();
    latch_mode = 1; latch_src = 2'd2;
    ptx(7, 4);
    cmd(C_SW);
    rd(7'd7, v); chk("R10 sw latch", v, 4);
    ptx(7, 1);
    fpulse();
    rd(7'd7, v); chk("R10 pin ignored", v, 4);
    cmd(C_SW);
    rd(7'd7, v); chk("R10 sw latch again", v, 1);
    latch_src = 2'd3;
    ptx(7, 2); cmd(C_SW); fpulse();
    latch_src = 2'd2; cmd(C_SW);
    rd(7'd7, v); chk("R10 src3 none", v, 2);
  endtask

  task automatic t_wrap16();
    logic [23:0] v;
    do_reset();
    wr(7'd2, 24'h12FFFF);
    latch_mode = 1; latch_src = 2'd3;
    sel(7'd2); cmd(C_EN);
    tx_evt[2] = 1; @(negedge clk); tx_evt[2] = 0;
    chk("R6 16-bit wrap pulse", irq_wrap, 80'd1 << 2);
    ptx(2, 1);
    latch_src = 2'd2; cmd(C_SW);
    rd(7'd2, v); chk("R6 after 16-bit wrap", v, 1);
  endtask

  task automatic t_range();
    logic [23:0] v;
    do_reset();
    wr(7'd36, 24'h000777);
    rd(7'd36, v);
    stage(24'h0A0B0C);
    sel(7'd100);
    cmd(C_WR);
    cmd(C_RD);
    chk("R11 stage_hi", stage_hi, 16'h000A);
    chk("R11 stage_lo", stage_lo, 16'h0B0C);
    cmd(C_EN);
    rd(7'd36, v); chk("R11 counter untouched", v, 24'h000777);
  endtask

  task automatic t_prescale();
    logic [23:0] v;
    do_reset();
    latch_mode = 1; latch_src = 2'd1;
    ptx(9, 5);
    for (int k = 0; k < 7999; k++) begin
      frame_pulse = 1; repeat (2) @(negedge clk);
      frame_pulse = 0; repeat (2) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    rd(7'd9, v); chk("R10 7999 edges none", v, 0);
    fpulse();
    rd(7'd9, v); chk("R10 8000th edge", v, 5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_map();
    t_rxen();
    t_read_hold();
    t_write_override();
    t_wrap_irq();
    t_latch_direct();
    t_latch_sw();
    t_wrap16();
    t_range();
    t_prescale();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule